// File: doc/BRIEF.md
# Clock Source Control and Ready-Flag Register Block

This block holds the software-visible controls of a clock-generation unit. Three 32-bit registers sit on a simple register bus. One enables the internal oscillator and the PLL. One requests a system clock source and sets the core clock divider. The third holds sticky ready flags, their interrupt enables and their clear controls. The block drives the enables, the PLL input choice, the divider setting and the source select for an external glitch-free mux. It does not generate any clock.

The oscillator and PLL models supply abstract stable and lock levels. Each rising edge of a source's ready condition sets a flag, and that flag stays set until software writes its clear bit. A switch tracker follows software's source request. It moves the active select only once the requested source is ready, so the reported status always names a running source.

The bus reads combinationally while `req_i` is high and writes on the clock edge when `we_i` is also high. Byte offsets 0x0, 0x4 and 0x8 decode to the control, configuration and interrupt registers. An access with a misaligned address, or to any other offset, is ignored and reads as 0.

Top module: `clkctl_top`

## Requirements
- R1: After reset, the control register reads 0x00000001 (internal oscillator on, PLL off). The configuration register reads 0. The interrupt register reads 0. `sys_sel_o`=0, `core_div_o`=0, `irq_o`=0, `int_osc_en_o`=1 and `pll_en_o`=0.
- R2: In the control register (offset 0x0), bit 0 is the internal-oscillator enable and drives `int_osc_en_o`. Bit 24 is the PLL enable and drives `pll_en_o`. Bit 25 is read-only and reads as PLL enable AND `pll_lock_i`. All other bits read 0 whatever is written.
- R3: In the configuration register (offset 0x4), bits [1:0] hold the requested source. Bits [7:4] hold the core divider, shown on `core_div_o`, where 0 means no division. Bit 16 holds the PLL input choice, shown on `pll_src_o`, where 0 means the internal oscillator. Bits [3:2] are read-only.
- R4: Sources are encoded 0 = internal oscillator, 1 = external oscillator, 2 = PLL, 3 = reserved. The reserved code is never ready. Bits [3:2] and `sys_sel_o` take the requested code at the first clock edge at which that source is ready, and otherwise keep their previous value. The readiness conditions are: internal = enable AND `int_osc_stable_i`; external = `ext_osc_stable_i`; PLL = enable AND `pll_lock_i`.
- R5: The interrupt register (offset 0x8) has sticky, read-only ready flags. Bit 0 is the low-speed oscillator, bit 2 the internal oscillator, bit 3 the external oscillator and bit 4 the PLL. Each flag sets on a rising edge of its source's readiness (the low-speed readiness is `slow_osc_stable_i`) and stays set after the readiness falls.
- R6: Interrupt-register bit 7, the clock-security flag, sets on every cycle in which `css_fault_i` is high, and it is sticky.
- R7: Writing 1 to bit 16, 18, 19, 20 or 23 clears flag bit 0, 2, 3, 4 or 7 respectively. The clear bits always read 0. Writes to the flag bits themselves have no effect.
- R8: When a flag's set condition and its clear write occur in the same cycle, the flag ends up set.
- R9: Interrupt-register bits 8, 10, 11 and 12 are read/write enables for flags 0, 2, 3 and 4. `irq_o` is high when any of these flags is set together with its enable, or whenever the clock-security flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read access |
| slow_osc_stable_i | input | 1 | Low-speed oscillator is stable |
| int_osc_stable_i | input | 1 | Internal oscillator is stable |
| ext_osc_stable_i | input | 1 | External oscillator is stable |
| pll_lock_i | input | 1 | PLL is locked |
| css_fault_i | input | 1 | Clock-security fault event |
| int_osc_en_o | output | 1 | Internal oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| pll_src_o | output | 1 | PLL input choice: 0 internal, 1 external |
| sys_sel_o | output | 2 | Active system clock source select |
| core_div_o | output | 4 | Core clock divider setting |
| irq_o | output | 1 | Clock interrupt request |

## Verification
The bench targets the cases a careless design gets wrong.

A source request to a source that is not ready must leave the status unchanged. A design that copies the request at once would report the PLL or external oscillator as active before it runs, or would accept the reserved code.

A clear write that lands in the same cycle as a new ready edge must leave the flag set. A design that lets the clear win would lose that event.

The bench also covers three further hazards:
- A flag that falls when readiness drops, which would show a design that is level-sensitive instead of sticky.
- Flag bits that software can set by writing them.
- A clock-security interrupt that stays masked when every enable is 0.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_PLL = 2'd2,
    SRC_RSV = 2'd3
  } clk_src_e;

  // register word indices (byte offset / 4)
  localparam int REG_CTL = 0;
  localparam int REG_CFG = 1;
  localparam int REG_INT = 2;

  // control fields
  localparam int CTL_INT_EN  = 0;
  localparam int CTL_PLL_EN  = 24;
  localparam int CTL_PLL_RDY = 25;

  // configuration fields
  localparam int CFG_SW_LSB  = 0;
  localparam int CFG_ACT_LSB = 2;
  localparam int CFG_DIV_LSB = 4;
  localparam int CFG_DIV_W   = 4;
  localparam int CFG_PLL_SRC = 16;

  // flag bank: index -> bit position in the interrupt register
  localparam int NUM_FLAGS = 5;
  localparam int NUM_IE    = 4;  // first NUM_IE flags own an enable
  localparam int FL_SLOW = 0;
  localparam int FL_INT  = 1;
  localparam int FL_EXT  = 2;
  localparam int FL_PLL  = 3;
  localparam int FL_CSS  = 4;
  localparam int unsigned FLAG_POS [NUM_FLAGS] = '{0, 2, 3, 4, 7};
  localparam int IE_OFS  = 8;   // enable bit = flag bit + IE_OFS
  localparam int CLR_OFS = 16;  // clear bit  = flag bit + CLR_OFS
endpackage

// File: rtl/clkctl_flags.sv
module clkctl_flags #(
  parameter int             N         = 5,
  parameter logic [N-1:0]   EDGE_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_flag
    logic set_w;
    logic flag_q;

    if (EDGE_MASK[gi]) begin : g_edge
      logic evt_d_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) evt_d_q <= 1'b0;
        else         evt_d_q <= evt_i[gi];
      end
      assign set_w = evt_i[gi] & ~evt_d_q;
    end else begin : g_level
      assign set_w = evt_i[gi];
    end

    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_w)     flag_q <= 1'b1;
      else if (clr_i[gi]) flag_q <= 1'b0;
    end

    assign flag_o[gi] = flag_q;
  end
endmodule

// File: rtl/clkctl_switch.sv
module clkctl_switch #(
  parameter int SEL_W = 2,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] req_sel_i,
  input  logic [NSRC-1:0]  src_rdy_i,
  output logic [SEL_W-1:0] act_sel_o
);
  logic [SEL_W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else if ((req_sel_i != act_q) && src_rdy_i[req_sel_i]) act_q <= req_sel_i;
  end

  assign act_sel_o = act_q;
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              slow_osc_stable_i,
  input  logic              int_osc_stable_i,
  input  logic              ext_osc_stable_i,
  input  logic              pll_lock_i,
  input  logic              css_fault_i,
  output logic              int_osc_en_o,
  output logic              pll_en_o,
  output logic              pll_src_o,
  output logic [1:0]        sys_sel_o,
  output logic [3:0]        core_div_o,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     idx;
  logic                 hit, wr_ctl, wr_cfg, wr_int;
  logic                 int_en_q, pll_en_q, pll_src_q;
  logic [1:0]           sw_q;
  logic [CFG_DIV_W-1:0] div_q;
  logic [NUM_IE-1:0]    ie_q;
  logic                 rdy_int, rdy_pll;
  logic [NUM_FLAGS-1:0] evt_vec, clr_vec, flag_vec;
  logic [1:0]           act_sel;
  logic [3:0]           src_rdy;
  logic                 unused_wdata;

  assign idx    = addr_i[ADDR_W-1:2];
  assign hit    = req_i & (addr_i[1:0] == 2'b00);
  assign wr_ctl = hit & we_i & (idx == IDX_W'(REG_CTL));
  assign wr_cfg = hit & we_i & (idx == IDX_W'(REG_CFG));
  assign wr_int = hit & we_i & (idx == IDX_W'(REG_INT));
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_q  <= 1'b1;
      pll_en_q  <= 1'b0;
      sw_q      <= SRC_INT;
      div_q     <= '0;
      pll_src_q <= 1'b0;
      ie_q      <= '0;
    end else begin
      if (wr_ctl) begin
        int_en_q <= wdata_i[CTL_INT_EN];
        pll_en_q <= wdata_i[CTL_PLL_EN];
      end
      if (wr_cfg) begin
        sw_q      <= wdata_i[CFG_SW_LSB +: 2];
        div_q     <= wdata_i[CFG_DIV_LSB +: CFG_DIV_W];
        pll_src_q <= wdata_i[CFG_PLL_SRC];
      end
      if (wr_int) begin
        for (int k = 0; k < NUM_IE; k++) ie_q[k] <= wdata_i[IE_OFS + FLAG_POS[k]];
      end
    end
  end

  // source readiness
  assign rdy_int = int_en_q & int_osc_stable_i;
  assign rdy_pll = pll_en_q & pll_lock_i;

  assign evt_vec[FL_SLOW] = slow_osc_stable_i;
  assign evt_vec[FL_INT]  = rdy_int;
  assign evt_vec[FL_EXT]  = ext_osc_stable_i;
  assign evt_vec[FL_PLL]  = rdy_pll;
  assign evt_vec[FL_CSS]  = css_fault_i;

  always_comb begin
    for (int k = 0; k < NUM_FLAGS; k++) clr_vec[k] = wr_int & wdata_i[CLR_OFS + FLAG_POS[k]];
  end

  clkctl_flags #(
    .N        (NUM_FLAGS),
    .EDGE_MASK(5'b01111)
  ) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_vec),
    .clr_i (clr_vec),
    .flag_o(flag_vec)
  );

  assign src_rdy[SRC_INT] = rdy_int;
  assign src_rdy[SRC_EXT] = ext_osc_stable_i;
  assign src_rdy[SRC_PLL] = rdy_pll;
  assign src_rdy[SRC_RSV] = 1'b0;

  clkctl_switch #(.SEL_W(2)) u_switch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_sel_i(sw_q),
    .src_rdy_i(src_rdy),
    .act_sel_o(act_sel)
  );

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      if (idx == IDX_W'(REG_CTL)) begin
        rdata_o[CTL_INT_EN]  = int_en_q;
        rdata_o[CTL_PLL_EN]  = pll_en_q;
        rdata_o[CTL_PLL_RDY] = rdy_pll;
      end else if (idx == IDX_W'(REG_CFG)) begin
        rdata_o[CFG_SW_LSB +: 2]          = sw_q;
        rdata_o[CFG_ACT_LSB +: 2]         = act_sel;
        rdata_o[CFG_DIV_LSB +: CFG_DIV_W] = div_q;
        rdata_o[CFG_PLL_SRC]              = pll_src_q;
      end else if (idx == IDX_W'(REG_INT)) begin
        for (int k = 0; k < NUM_FLAGS; k++) rdata_o[FLAG_POS[k]] = flag_vec[k];
        for (int k = 0; k < NUM_IE; k++)    rdata_o[IE_OFS + FLAG_POS[k]] = ie_q[k];
      end
    end
  end

  assign int_osc_en_o = int_en_q;
  assign pll_en_o     = pll_en_q;
  assign pll_src_o    = pll_src_q;
  assign sys_sel_o    = act_sel;
  assign core_div_o   = div_q;
  assign irq_o        = (|(flag_vec[NUM_IE-1:0] & ie_q)) | flag_vec[FL_CSS];
endmodule

// File: rtl/clkctl_top_chk.sv
module clkctl_top_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              clr_pll_bit_i,
  input logic              pll_en_o,
  input logic              pll_lock_i,
  input logic              css_fault_i,
  input logic [1:0]        sys_sel_o,
  input logic [1:0]        sw_q,
  input logic              flag_pll_i,
  input logic              flag_css_i,
  input logic              ie_pll_i,
  input logic              irq_o
);
  logic clr_pll_wr;
  logic pll_rdy;
  assign clr_pll_wr = req_i & we_i & (addr_i == ADDR_W'(8)) & clr_pll_bit_i;
  assign pll_rdy    = pll_en_o & pll_lock_i;

  assert_sel_follows_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_sel_o != $past(sys_sel_o)) |-> (sys_sel_o == $past(sw_q)));

  assert_pll_sel_needs_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sys_sel_o == 2'd2) && ($past(sys_sel_o) != 2'd2)) |-> $past(pll_rdy));

  assert_pll_flag_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_rdy) |=> flag_pll_i);

  assert_pll_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_pll_i && !clr_pll_wr) |=> flag_pll_i);

  assert_css_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    css_fault_i |=> flag_css_i);

  assert_pll_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pll_wr && !pll_rdy) |=> !flag_pll_i);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pll_wr && $rose(pll_rdy)) |=> flag_pll_i);

  assert_irq_enabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_pll_i && ie_pll_i) |-> irq_o);

  assert_irq_css_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_css_i |-> irq_o);
endmodule

bind clkctl_top clkctl_top_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .clr_pll_bit_i(wdata_i[20]),
  .pll_en_o     (pll_en_o),
  .pll_lock_i   (pll_lock_i),
  .css_fault_i  (css_fault_i),
  .sys_sel_o    (sys_sel_o),
  .sw_q         (sw_q),
  .flag_pll_i   (flag_vec[3]),
  .flag_css_i   (flag_vec[4]),
  .ie_pll_i     (ie_q[3]),
  .irq_o        (irq_o)
);

// File: tb/clkctl_top_tb.sv
module clkctl_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        slow_st = 0, int_st = 0, ext_st = 0, lock = 0, css = 0;
  logic        int_en, pll_en, pll_src, irq;
  logic [1:0]  sel;
  logic [3:0]  div;
  int          total = 0, bad = 0;
  logic [31:0] rd_v;

  always #2 clk = ~clk;

  clkctl_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .slow_osc_stable_i(slow_st), .int_osc_stable_i(int_st),
    .ext_osc_stable_i(ext_st), .pll_lock_i(lock), .css_fault_i(css),
    .int_osc_en_o(int_en), .pll_en_o(pll_en), .pll_src_o(pll_src),
    .sys_sel_o(sel), .core_div_o(div), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (3) tick(); rst_n = 1;
    rd(4'h0, rd_v); chk("R1 ctl", rd_v, 32'h1);
    rd(4'h4, rd_v); chk("R1 cfg", rd_v, 32'h0);
    rd(4'h8, rd_v); chk("R1 int", rd_v, 32'h0);
    chk("R1 outputs", {20'd0, int_en, pll_en, sel, div, irq, pll_src},
        {20'd0, 1'b1, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0});
  endtask

  task automatic t_flags();
    tick(); int_st = 1; slow_st = 1;
    rd(4'h8, rd_v); chk("R5 slow+int set", rd_v, 32'h5);
    tick(); int_st = 0;
    rd(4'h8, rd_v); chk("R5 sticky after fall", rd_v, 32'h5);
    wr(4'h0, 32'h0100_0001);
    tick(); lock = 1;
    rd(4'h0, rd_v); chk("R2 pll ready bit", rd_v, 32'h0300_0001);
    rd(4'h8, rd_v); chk("R5 pll flag", rd_v, 32'h15);
    chk("R9 no irq w/o enable", irq, 0);
  endtask

  task automatic t_ctl();
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, rd_v); chk("R2 ctl mask", rd_v, 32'h0300_0001);
    wr(4'h0, 32'h0100_0000);
    chk("R2 int osc off", {pll_en, int_en}, 2'b10);
    wr(4'h0, 32'h0100_0001);
    chk("R2 int osc on", int_en, 1);
  endtask

  task automatic t_clear();
    wr(4'h8, 32'h0010_0000);
    rd(4'h8, rd_v); chk("R7 clear pll", rd_v, 32'h5);
    wr(4'h8, 32'h0000_00FF);
    rd(4'h8, rd_v); chk("R7 flags not writable", rd_v, 32'h5);
    wr(4'h8, 32'h0005_0000);
    rd(4'h8, rd_v); chk("R7 clear slow+int", rd_v, 32'h0);
  endtask

  task automatic t_set_wins();
    tick(); lock = 0;
    tick();
    @(negedge clk); lock = 1; req = 1; we = 1; addr = 4'h8; wdata = 32'h0010_0000;
    @(negedge clk); req = 0; we = 0; wdata = '0;
    rd(4'h8, rd_v); chk("R8 set beats clear", rd_v, 32'h10);
  endtask

  task automatic t_irq();
    wr(4'h8, 32'h0000_1000);
    chk("R9 irq pll enabled", irq, 1);
    rd(4'h8, rd_v); chk("R9 enable readback", rd_v, 32'h1010);
    wr(4'h8, 32'h0010_1000);
    chk("R9 irq drops on clear", irq, 0);
    wr(4'h8, 32'h0000_0100);
    tick(); slow_st = 0;
    tick(); slow_st = 1;
    tick();
    chk("R9 irq slow enabled", irq, 1);
    wr(4'h8, 32'h0001_0000);
    chk("R9 irq slow cleared", irq, 0);
  endtask

  task automatic t_css();
    wr(4'h8, 32'h0);
    tick(); css = 1;
    tick(); css = 0;
    rd(4'h8, rd_v); chk("R6 css flag", rd_v, 32'h80);
    chk("R9 css irq unmasked", irq, 1);
    wr(4'h8, 32'h0080_0000);
    rd(4'h8, rd_v); chk("R7 css clear", rd_v, 32'h0);
  endtask

  task automatic t_switch();
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h2);
    tick();
    rd(4'h4, rd_v); chk("R4 pll off keeps int", rd_v, 32'h2);
    chk("R4 sel int", sel, 0);
    wr(4'h0, 32'h0100_0001);
    rd(4'h4, rd_v); chk("R4 switch to pll", rd_v, 32'hA);
    chk("R4 sel pll", sel, 2);
    wr(4'h4, 32'h0001_005E);
    rd(4'h4, rd_v); chk("R3 cfg fields", rd_v, 32'h0001_005A);
    chk("R3 div/src outputs", {div, pll_src}, {4'd5, 1'b1});
    wr(4'h4, 32'h0001_0051);
    tick();
    rd(4'h4, rd_v); chk("R4 ext not ready", rd_v, 32'h0001_0059);
    tick(); ext_st = 1;
    rd(4'h4, rd_v); chk("R4 ext ready", rd_v, 32'h0001_0055);
    chk("R4 sel ext", sel, 1);
    wr(4'h4, 32'h0001_0053);
    tick();
    rd(4'h4, rd_v); chk("R4 reserved ignored", rd_v, 32'h0001_0057);
    wr(4'h4, 32'h0001_0050);
    rd(4'h4, rd_v); chk("R4 int not stable", rd_v, 32'h0001_0054);
    tick(); int_st = 1;
    rd(4'h4, rd_v); chk("R4 back to int", rd_v, 32'h0001_0050);
    chk("R4 sel int again", sel, 0);
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_flags();
    t_ctl();
    t_clear();
    t_set_wins();
    t_irq();
    t_css();
    t_switch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule